// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block picks the power mode of a small microcontroller. Each time the CPU raises a stop request, the block reads a set of software control bits and decides between wait, a fully regulated stop, loose-regulation standby and partial power-down. Standby can also be entered straight from run through a low-power request bit, without any stop request. The block drives the regulator mode and a logic power-gate enable from the chosen mode.

Several conditions limit the choice. Standby and power-down are blocked while debugging in low-power states is enabled. Standby also needs a slow bus clock. A forbidden bit combination, or a stop request that neither enable bit permits, is refused with an error, a reset request or an exception. Once a low-power mode is entered it is held until a wake request returns the block to run. Waking from power-down goes through a reset request, because the logic state is lost there. A separate debug halt state sits beside the power modes and leaves the regulator fully on.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset, `mode` is 0 (run), and `reg_loose`, `pgate_en`, `rst_req`, `ill_exc` and `combo_err` are all 0. Mode codes: run 0, wait 1, stop 2, standby 3, power-down 4, halt 5.
- R2: In run, a stop request with `wait_en` set gives mode 1 (wait) on the next cycle, whatever `stop_en` is.
- R3: In run, a stop request with `wait_en` clear and `stop_en` set, and no low-power selection, gives mode 2 (stop) with `reg_loose` 0.
- R4: In run, a stop request with both `wait_en` and `stop_en` clear keeps mode 0. It pulses `rst_req` for one cycle if `ill_rst_dis` is 0, or pulses `ill_exc` for one cycle if `ill_rst_dis` is 1.
- R5: In run, a legal stop with `ppd_sel` set gives mode 4. In mode 4 both `reg_loose` and `pgate_en` are 1.
- R6: Standby (mode 3, `reg_loose` 1, `pgate_en` 0) is entered when `lp_req` is set and `slow_bus` is 1, either on a legal stop or directly from run with no stop request. With `slow_bus` 0, a stop gives mode 2 and a direct request leaves the block in run.
- R7: While `dbg_lp_en` is 1, a legal stop gives mode 2 even with `ppd_sel` or `lp_req` set, and no direct entry into standby happens.
- R8: In run, with `ppd_sel` and `lp_req` both 1, no low-power transition happens. The mode stays 0 and `combo_err` is 1 on the next cycle.
- R9: In modes 1 to 4, every input except `wake` is ignored, and the mode does not change.
- R10: `wake` in mode 1, 2 or 3 gives mode 0 on the next cycle with no `rst_req`.
- R11: `wake` in mode 4 gives mode 0 and a one-cycle `rst_req` on the next cycle.
- R12: `dbg_halt` in run gives mode 5 on the next cycle, with `reg_loose` and `pgate_en` both 0. Stop requests are ignored in mode 5, and the block returns to mode 0 the cycle after `dbg_halt` falls. `dbg_halt` takes priority over a stop request sampled in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | CPU stop request |
| wait_en | input | 1 | Stop request resolves to wait |
| stop_en | input | 1 | Stop request resolves to a stop mode |
| ppd_sel | input | 1 | Stop resolves to partial power-down |
| lp_req | input | 1 | Low-power (standby) request |
| dbg_lp_en | input | 1 | Debug allowed in low power; blocks standby and power-down |
| ill_rst_dis | input | 1 | Illegal stop gives an exception instead of a reset |
| slow_bus | input | 1 | Bus clock is below the standby limit |
| wake | input | 1 | Wake request |
| dbg_halt | input | 1 | Debug halt request (level) |
| mode | output | 3 | Current mode code |
| reg_loose | output | 1 | Regulator in loose regulation |
| pgate_en | output | 1 | Logic power gate switched off |
| rst_req | output | 1 | Reset request pulse |
| ill_exc | output | 1 | Illegal-instruction exception pulse |
| combo_err | output | 1 | Forbidden bit combination flag |

## Verification
Several requests can arrive in the same run cycle, and the block must resolve them by priority. The bench raises `dbg_halt` together with a stop request, and raises the forbidden `ppd_sel`/`lp_req` pair together with a stop request that would otherwise be illegal. In the first case the expected result is halt with no pulses. In the second case the expected result is only `combo_err`, with no reset or exception. A behavioural model in the bench predicts every output on every cycle, and any difference is reported against the requirement being exercised.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        M_RUN  = 3'd0,
        M_WAIT = 3'd1,
        M_STOP = 3'd2,
        M_STBY = 3'd3,
        M_PPD  = 3'd4,
        M_HALT = 3'd5
    } pmode_e;

    typedef struct packed {
        pmode_e mode;
        logic   rst_req;
        logic   ill_exc;
        logic   combo_err;
    } pstate_t;
endpackage

// File: rtl/pwr_stop_resolve.sv
module pwr_stop_resolve
    import pwr_mode_pkg::*;
(
    input  logic   wait_en,
    input  logic   stop_en,
    input  logic   ppd_sel,
    input  logic   lp_req,
    input  logic   dbg_lp_en,
    input  logic   slow_bus,
    output pmode_e tgt,
    output logic   legal,
    output logic   combo,
    output logic   direct_stby
);
    logic stby_ok;

    always_comb begin
        stby_ok     = lp_req && slow_bus && !dbg_lp_en;
        combo       = ppd_sel && lp_req;
        direct_stby = stby_ok && !ppd_sel;
        legal       = wait_en || stop_en;
        tgt         = M_RUN;
        if (wait_en) begin
            tgt = M_WAIT;
        end else if (stop_en) begin
            if (dbg_lp_en)    tgt = M_STOP;
            else if (ppd_sel) tgt = M_PPD;
            else if (stby_ok) tgt = M_STBY;
            else              tgt = M_STOP;
        end
    end
endmodule

// File: rtl/pwr_out_map.sv
module pwr_out_map
    import pwr_mode_pkg::*;
(
    input  pmode_e mode,
    output logic   reg_loose,
    output logic   pgate_en
);
    always_comb begin
        reg_loose = (mode == M_STBY) || (mode == M_PPD);
        pgate_en  = (mode == M_PPD);
    end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pwr_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_req,
    input  logic              wait_en,
    input  logic              stop_en,
    input  logic              ppd_sel,
    input  logic              lp_req,
    input  logic              dbg_lp_en,
    input  logic              ill_rst_dis,
    input  logic              slow_bus,
    input  logic              wake,
    input  logic              dbg_halt,
    output logic [MODE_W-1:0] mode,
    output logic              reg_loose,
    output logic              pgate_en,
    output logic              rst_req,
    output logic              ill_exc,
    output logic              combo_err
);
    pstate_t st_d, st_q;
    pmode_e  tgt;
    logic    legal, combo, direct_stby;

    pwr_stop_resolve u_resolve (
        .wait_en     (wait_en),
        .stop_en     (stop_en),
        .ppd_sel     (ppd_sel),
        .lp_req      (lp_req),
        .dbg_lp_en   (dbg_lp_en),
        .slow_bus    (slow_bus),
        .tgt         (tgt),
        .legal       (legal),
        .combo       (combo),
        .direct_stby (direct_stby)
    );

    pwr_out_map u_out (
        .mode      (st_q.mode),
        .reg_loose (reg_loose),
        .pgate_en  (pgate_en)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rst_req   = 1'b0;
        st_d.ill_exc   = 1'b0;
        st_d.combo_err = 1'b0;
        case (st_q.mode)
            M_RUN: begin
                if (dbg_halt) begin
                    st_d.mode = M_HALT;
                end else if (combo) begin
                    st_d.combo_err = 1'b1;
                end else if (stop_req) begin
                    if (legal)            st_d.mode    = tgt;
                    else if (ill_rst_dis) st_d.ill_exc = 1'b1;
                    else                  st_d.rst_req = 1'b1;
                end else if (direct_stby) begin
                    st_d.mode = M_STBY;
                end
            end
            M_WAIT, M_STOP, M_STBY: begin
                if (wake) st_d.mode = M_RUN;
            end
            M_PPD: begin
                if (wake) begin
                    st_d.mode    = M_RUN;
                    st_d.rst_req = 1'b1;
                end
            end
            M_HALT: begin
                if (!dbg_halt) st_d.mode = M_RUN;
            end
            default: st_d.mode = M_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{M_RUN, 1'b0, 1'b0, 1'b0};
        else        st_q <= st_d;
    end

    assign mode      = st_q.mode;
    assign rst_req   = st_q.rst_req;
    assign ill_exc   = st_q.ill_exc;
    assign combo_err = st_q.combo_err;

    p_wait_prio_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_RUN && !dbg_halt && !(ppd_sel && lp_req) && stop_req && wait_en)
        |=> (mode == 3'd1));

    p_fast_no_stby_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_RUN && !slow_bus) |=> (mode != 3'd3));

    p_dbg_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_RUN && dbg_lp_en) |=> !reg_loose);

    p_combo_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_RUN && ppd_sel && lp_req && !dbg_halt)
        |=> (mode == 3'd0 && combo_err && !rst_req && !ill_exc));

    p_lp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mode == M_WAIT || st_q.mode == M_STOP || st_q.mode == M_STBY ||
          st_q.mode == M_PPD) && !wake) |=> $stable(mode));

    p_ppd_wake_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_PPD && wake) |=> (mode == 3'd0 && rst_req));

    p_halt_full_reg_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_RUN && dbg_halt) |=> (mode == 3'd5 && !reg_loose && !pgate_en));
endmodule

// File: tb/test_pwr_mode_seq.sv
module test_pwr_mode_seq;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 0, wait_en = 0, stop_en = 0, ppd_sel = 0, lp_req = 0;
    logic dbg_lp_en = 0, ill_rst_dis = 0, slow_bus = 0, wake = 0, dbg_halt = 0;
    logic [2:0] mode;
    logic reg_loose, pgate_en, rst_req, ill_exc, combo_err;

    int n_checks = 0;
    int n_fail = 0;
    string cur_req = "R1";

    int   m_mode = 0;
    logic m_rst = 0, m_exc = 0, m_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_mode_seq i_pwr_mode_seq (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wait_en(wait_en),
        .stop_en(stop_en), .ppd_sel(ppd_sel), .lp_req(lp_req),
        .dbg_lp_en(dbg_lp_en), .ill_rst_dis(ill_rst_dis), .slow_bus(slow_bus),
        .wake(wake), .dbg_halt(dbg_halt), .mode(mode), .reg_loose(reg_loose),
        .pgate_en(pgate_en), .rst_req(rst_req), .ill_exc(ill_exc),
        .combo_err(combo_err)
    );

    // Behavioural reference: priority list taken from the requirements.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_rst = 0; m_exc = 0; m_err = 0;
        end else begin
            m_rst = 0; m_exc = 0; m_err = 0;
            if (m_mode == 0) begin
                if (dbg_halt)                 m_mode = 5;          // R12
                else if (ppd_sel && lp_req)   m_err = 1;           // R8
                else if (stop_req) begin
                    if (wait_en)              m_mode = 1;          // R2
                    else if (!stop_en) begin                       // R4
                        if (ill_rst_dis) m_exc = 1; else m_rst = 1;
                    end
                    else if (dbg_lp_en)       m_mode = 2;          // R7
                    else if (ppd_sel)         m_mode = 4;          // R5
                    else if (lp_req && slow_bus) m_mode = 3;       // R6
                    else                      m_mode = 2;          // R3
                end
                else if (lp_req && slow_bus && !dbg_lp_en) m_mode = 3;
            end else if (m_mode == 5) begin
                if (!dbg_halt) m_mode = 0;
            end else if (wake) begin                               // R10, R11
                if (m_mode == 4) m_rst = 1;
                m_mode = 0;
            end
        end
    end

    task automatic compare();
        logic [7:0] act, exp;
        act = {mode, reg_loose, pgate_en, rst_req, ill_exc, combo_err};
        exp = {m_mode[2:0], (m_mode == 3 || m_mode == 4), (m_mode == 4), m_rst, m_exc, m_err};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {mode,loose,gate,rst,exc,err} actual=%b expected=%b at %0t",
                     cur_req, act, exp, $time);
        end
    endtask

    task automatic tick(input string tag, input int n);
        cur_req = tag;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            compare();
        end
    endtask

    task automatic idle();
        stop_req = 0; wait_en = 0; stop_en = 0; ppd_sel = 0; lp_req = 0;
        dbg_lp_en = 0; ill_rst_dis = 0; slow_bus = 0; wake = 0; dbg_halt = 0;
    endtask

    task automatic do_wake(input string tag);
        idle(); wake = 1; tick(tag, 1); wake = 0; tick(tag, 1);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        cur_req = "R1"; compare();
        rst_n = 1;
        tick("R1", 2);

        // R2: wait wins over stop_en
        wait_en = 1; stop_en = 1; stop_req = 1; tick("R2", 1);
        stop_req = 0; tick("R2", 2);
        do_wake("R10");
        // R3: plain stop
        stop_en = 1; stop_req = 1; tick("R3", 1); idle(); tick("R3", 2);
        do_wake("R10");
        // R4: illegal stop, reset path then exception path
        stop_req = 1; tick("R4", 2);
        ill_rst_dis = 1; tick("R4", 2); idle(); tick("R4", 1);
        // R5: power-down, then R11 wake
        stop_en = 1; ppd_sel = 1; stop_req = 1; slow_bus = 1; tick("R5", 1);
        idle(); tick("R5", 3);
        do_wake("R11");
        // R6: standby via stop with slow bus, via stop with fast bus, direct
        stop_en = 1; lp_req = 1; slow_bus = 1; stop_req = 1; tick("R6", 1);
        idle(); tick("R6", 1); do_wake("R10");
        stop_en = 1; lp_req = 1; slow_bus = 0; stop_req = 1; tick("R6", 1);
        idle(); tick("R6", 1); do_wake("R10");
        lp_req = 1; slow_bus = 1; tick("R6", 1); idle(); tick("R6", 1);
        // R9: ignore other requests while in standby
        stop_req = 1; stop_en = 1; ppd_sel = 1; dbg_halt = 1; tick("R9", 2);
        idle(); tick("R9", 1); do_wake("R10");
        lp_req = 1; slow_bus = 0; tick("R6", 3); idle();
        // R7: debug enable blocks power-down and standby
        dbg_lp_en = 1; stop_en = 1; ppd_sel = 1; stop_req = 1; tick("R7", 1);
        idle(); tick("R7", 1); do_wake("R10");
        dbg_lp_en = 1; lp_req = 1; slow_bus = 1; tick("R7", 3); idle();
        // R8: forbidden pair with an otherwise illegal stop request
        ppd_sel = 1; lp_req = 1; slow_bus = 1; stop_req = 1; tick("R8", 3);
        stop_en = 1; tick("R8", 1); idle(); tick("R8", 1);
        // R12: halt beats stop request, stop ignored while halted
        dbg_halt = 1; stop_req = 1; stop_en = 1; tick("R12", 3);
        stop_req = 0; dbg_halt = 0; tick("R12", 2);
        // R9: wait ignores halt and illegal bits
        wait_en = 1; stop_req = 1; tick("R9", 1);
        wait_en = 0; stop_en = 0; dbg_halt = 1; ppd_sel = 1; lp_req = 1; tick("R9", 2);
        idle(); do_wake("R10");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule